// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block gathers the four interrupt pins (INTA to INTD) of a fixed set of PCI device positions and drives a 16-line ISA interrupt vector. First, a swizzle fixed at elaboration folds every device pin onto one of four shared interrupt channels. The mapping depends on the slot number that each device position is given by parameter.

Four byte-wide route registers, one per channel, sit behind a simple configuration port. Writes are synchronous and reads are combinational. A purely combinational fan-in then raises each ISA line while any active channel is routed to it.

All interrupt inputs are active-high levels. The router adds no latching and no edge detection, so an ISA line follows its sources within the same cycle.

Top module: `pirq_router`

## Requirements
- R1: After reset the route registers read 0x0A for channels 0 and 1 and 0x0B for channels 2 and 3. Channels 0 to 3 sit at configuration offsets 0x60 to 0x63 in that order.
- R2: A write with `cfg_we` high at offset 0x60+k stores `cfg_wdata` in route register k, and `cfg_rdata` returns that value while `cfg_addr` selects it. Writes to any other offset change nothing, and reads of any other offset return 0x00.
- R3: A routing change applies to `isa_irq` as observed after the clock edge that accepts the write. Before that edge the old routing applies.
- R4: A route value from 0 to 15 steers its channel to the ISA line of that number. A value of 16 or more leaves the channel connected to no line.
- R5: When several channels hold the same route value, that ISA line is high while any of those channels is active.
- R6: An ISA line that no active channel is routed to is driven low.
- R7: A device in slot 10 always feeds channel 3, slot 11 feeds channel 1 and slot 12 feeds channel 2, whichever pin is asserted.
- R8: A device in slots 18 to 21 feeds channel ((slot − 18) + pin) mod 4, where pin 0 to 3 means INTA to INTD.
- R9: A device in any other slot feeds the channel equal to its pin number.
- R10: `isa_irq` follows the level inputs combinationally: it rises and falls in the same cycle as the sources, with no holding or edge detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration port |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally |
| dev_int | input | NUM_DEV*4 | Device interrupt pins. Device d pin p is bit d*4+p, and pin 0 to 3 means INTA to INTD |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Combinational read data for `cfg_addr` |
| isa_irq | output | 16 | ISA interrupt levels; bit n is ISA line n |

## Verification
The hardest case to reach from the ports is several channels merging onto one ISA line while one of their sources drops. The OR behaviour only shows when a line must stay high after one of its contributors has gone low. The stimulus first rewrites every route register to a common line. It then asserts and releases device pins from different slots one at a time, so that contributors overlap. Route values at the 15/16 border, and stray writes to the offsets around the register window, are interleaved with live interrupt traffic. This exposes routing changes and ignored writes in the same cycle as the level changes.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

  localparam int NUM_PIRQ   = 4;
  localparam int PINS       = 4;
  localparam int ROUTE_W    = 8;
  localparam int ISA_LINES  = 16;
  localparam int SLOT_W     = 5;
  localparam int ISA_IDX_W  = $clog2(ISA_LINES);

  localparam logic [ROUTE_W-1:0] ROUTE_BASE = 8'h60;

  typedef logic [NUM_PIRQ-1:0][ROUTE_W-1:0] route_bank_t;

  // Value a route register takes while reset is asserted
  function automatic logic [ROUTE_W-1:0] route_reset_value(input int chan);
    return (chan < 2) ? 8'h0A : 8'h0B;
  endfunction

  // Slot/pin to channel swizzle, evaluated on constant slot numbers
  function automatic logic [1:0] pirq_map(input logic [SLOT_W-1:0] slot,
                                          input logic [1:0]        pin);
    logic [SLOT_W-1:0] off;
    off = slot - SLOT_W'(18);
    if (slot == SLOT_W'(10))      return 2'd3;
    else if (slot == SLOT_W'(11)) return 2'd1;
    else if (slot == SLOT_W'(12)) return 2'd2;
    else if (slot >= SLOT_W'(18) && slot <= SLOT_W'(21)) return off[1:0] + pin;
    else                          return pin;
  endfunction

endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter logic [NUM_DEV*SLOT_W-1:0] DEV_SLOTS = '0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_DEV*PINS-1:0]    dev_int,
  output logic [NUM_PIRQ-1:0]        pirq_level
);

  // Slot numbers are parameters, so every index below folds to a constant
  always_comb begin
    pirq_level = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int p = 0; p < PINS; p++) begin
        pirq_level[pirq_map(DEV_SLOTS[d*SLOT_W +: SLOT_W], 2'(p))] =
          pirq_level[pirq_map(DEV_SLOTS[d*SLOT_W +: SLOT_W], 2'(p))] |
          dev_int[d*PINS + p];
      end
    end
  end

  // R9 and R7/R8 share this: no device activity means no channel activity
  a_r9_quiet_channels: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_int == '0) |-> (pirq_level == '0));

  // R10: channel activity never outnumbers asserted pins
  a_r10_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pirq_level) <= $countones(dev_int));

endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [7:0]          cfg_addr,
  input  logic [ROUTE_W-1:0]  cfg_wdata,
  output logic [ROUTE_W-1:0]  cfg_rdata,
  output route_bank_t         route
);

  localparam int WIN_LSB = $clog2(NUM_PIRQ);

  logic [NUM_PIRQ-1:0] wr_hit;
  logic                in_window;
  logic [WIN_LSB-1:0]  rd_idx;

  for (genvar k = 0; k < NUM_PIRQ; k++) begin : g_chan
    logic [ROUTE_W-1:0] route_nxt;

    assign wr_hit[k] = cfg_we && (cfg_addr == 8'(ROUTE_BASE + k));

    always_comb begin
      route_nxt = route[k];
      if (wr_hit[k]) route_nxt = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         route[k] <= route_reset_value(k);
      else if (wr_hit[k]) route[k] <= route_nxt;
    end

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[k] |=> (route[k] == $past(cfg_wdata)));
  end

  assign in_window = (cfg_addr[7:WIN_LSB] == ROUTE_BASE[7:WIN_LSB]);
  assign rd_idx    = cfg_addr[WIN_LSB-1:0];

  always_comb begin
    cfg_rdata = '0;
    if (in_window) cfg_rdata = route[rd_idx];
  end

  a_r2_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(route));

  a_r1_reset_values: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (route[0] == 8'h0A && route[1] == 8'h0A &&
                      route[2] == 8'h0B && route[3] == 8'h0B));

endmodule

// File: rtl/pirq_isa_fanin.sv
module pirq_isa_fanin
  import pirq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PIRQ-1:0]   pirq_level,
  input  route_bank_t           route,
  output logic [ISA_LINES-1:0]  isa_irq
);

  for (genvar i = 0; i < ISA_LINES; i++) begin : g_line
    logic [NUM_PIRQ-1:0] sel;
    always_comb begin
      for (int k = 0; k < NUM_PIRQ; k++) begin
        // The full byte is compared, so 16 and above never match a line
        sel[k] = pirq_level[k] && (route[k] == ROUTE_W'(i));
      end
    end
    assign isa_irq[i] = |sel;
  end

  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_level == '0) |-> (isa_irq == '0));

  a_r5_merge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isa_irq) <= $countones(pirq_level));

  a_r4_unrouted_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (route[0] >= 8'd16 && route[1] >= 8'd16 &&
     route[2] >= 8'd16 && route[3] >= 8'd16) |-> (isa_irq == '0));

endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_pkg::*;
#(
  parameter int NUM_DEV = 8,
  parameter logic [NUM_DEV*SLOT_W-1:0] DEV_SLOTS =
    {5'd5, 5'd21, 5'd20, 5'd19, 5'd18, 5'd12, 5'd11, 5'd10}
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_DEV*PINS-1:0]   dev_int,
  input  logic                      cfg_we,
  input  logic [7:0]                cfg_addr,
  input  logic [ROUTE_W-1:0]        cfg_wdata,
  output logic [ROUTE_W-1:0]        cfg_rdata,
  output logic [ISA_LINES-1:0]      isa_irq
);

  logic [1:0]          rst_pipe;
  logic                rst_int_n;
  logic [NUM_PIRQ-1:0] pirq_level;
  route_bank_t         route;

  // Assert asynchronously, release on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  pirq_swizzle #(.NUM_DEV(NUM_DEV), .DEV_SLOTS(DEV_SLOTS)) u_swizzle (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .dev_int    (dev_int),
    .pirq_level (pirq_level)
  );

  pirq_route_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .route     (route)
  );

  pirq_isa_fanin u_fanin (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .pirq_level (pirq_level),
    .route      (route),
    .isa_irq    (isa_irq)
  );

  a_r10_silent_inputs: assert property (@(posedge clk) disable iff (!rst_int_n)
    (dev_int == '0) |-> (isa_irq == '0));

endmodule

// File: tb/tb_pirq_router.sv
`timescale 1ns/1ps
module tb_pirq_router;

  localparam int ND = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [ND*4-1:0] dev_int;
  logic          cfg_we;
  logic [7:0]    cfg_addr;
  logic [7:0]    cfg_wdata;
  logic [7:0]    cfg_rdata;
  logic [15:0]   isa_irq;

  int compared = 0;
  int mismatched = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;
  string phase = "R1";

  int slots [ND] = '{10, 11, 12, 18, 19, 20, 21, 5};
  int mroute [4];

  always #2.5 clk = ~clk;

  pirq_router dut (
    .clk(clk), .rst_n(rst_n), .dev_int(dev_int), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .isa_irq(isa_irq)
  );

  function automatic int exp_chan(int slot, int pin);
    if (slot == 10) return 3;
    if (slot == 11) return 1;
    if (slot == 12) return 2;
    if (slot >= 18 && slot <= 21) return ((slot - 18) + pin) % 4;
    return pin;
  endfunction

  function automatic logic [15:0] exp_isa();
    logic [15:0] v = '0;
    for (int d = 0; d < ND; d++)
      for (int p = 0; p < 4; p++)
        if (dev_int[d*4+p]) begin
          int c = exp_chan(slots[d], p);
          if (mroute[c] < 16) v[mroute[c]] = 1'b1;
        end
    return v;
  endfunction

  function automatic logic [7:0] exp_rd();
    if (cfg_addr >= 8'h60 && cfg_addr <= 8'h63) return 8'(mroute[cfg_addr - 8'h60]);
    return 8'h00;
  endfunction

  // Reference model state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mroute[0] = 8'h0A; mroute[1] = 8'h0A; mroute[2] = 8'h0B; mroute[3] = 8'h0B;
    end else if (cfg_we && cfg_addr >= 8'h60 && cfg_addr <= 8'h63) begin
      mroute[cfg_addr - 8'h60] = int'(cfg_wdata);
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (chk_en && !done) begin
      logic [15:0] ei;
      logic [7:0]  er;
      ei = exp_isa();
      er = exp_rd();
      compared++;
      if (isa_irq !== ei) begin
        mismatched++;
        $display("FAIL %s isa_irq actual=%h expected=%h", phase, isa_irq, ei);
      end
      compared++;
      if (cfg_rdata !== er) begin
        mismatched++;
        $display("FAIL %s cfg_rdata@%h actual=%h expected=%h", phase, cfg_addr, cfg_rdata, er);
      end
    end
  end

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
    tick();
  endtask

  task automatic rd(input logic [7:0] a);
    cfg_addr = a;
    tick();
  endtask

  task automatic pulse_each_pin();
    for (int b = 0; b < ND*4; b++) begin
      dev_int = '0; dev_int[b] = 1'b1;
      tick();
    end
    dev_int = '0;
    tick();
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; dev_int = '0; cfg_we = 1'b0; cfg_addr = 8'h00; cfg_wdata = 8'h00;
    repeat (4) tick();
    chk_en = 1'b1;
    rst_n = 1'b1;
    repeat (4) tick();

    phase = "R1";
    for (int a = 8'h5E; a <= 8'h66; a++) rd(8'(a));

    phase = "R7";
    cfg_addr = 8'h60;
    for (int b = 0; b < 12; b++) begin dev_int = '0; dev_int[b] = 1'b1; tick(); end
    dev_int = '0; tick();

    phase = "R8";
    wr(8'h60, 8'd0); wr(8'h61, 8'd1); wr(8'h62, 8'd2); wr(8'h63, 8'd3);
    for (int b = 12; b < 28; b++) begin dev_int = '0; dev_int[b] = 1'b1; tick(); end

    phase = "R9";
    for (int b = 28; b < 32; b++) begin dev_int = '0; dev_int[b] = 1'b1; tick(); end
    dev_int = '0; tick();
    pulse_each_pin();

    phase = "R5";
    wr(8'h60, 8'd5); wr(8'h61, 8'd5); wr(8'h62, 8'd5); wr(8'h63, 8'd5);
    dev_int[4]  = 1'b1; tick();
    dev_int[8]  = 1'b1; tick();
    dev_int[4]  = 1'b0; tick();
    dev_int[0]  = 1'b1; tick();
    dev_int[8]  = 1'b0; tick();
    dev_int[0]  = 1'b0; tick();

    phase = "R4";
    wr(8'h61, 8'd16); wr(8'h62, 8'd15); wr(8'h63, 8'hFF); wr(8'h60, 8'd0);
    dev_int = 32'hF000_0000; tick();
    dev_int = '1; tick();
    pulse_each_pin();

    phase = "R3";
    dev_int = 32'h0000_F000;
    cfg_we = 1'b1; cfg_addr = 8'h60; cfg_wdata = 8'd7; tick();
    cfg_wdata = 8'd9; cfg_addr = 8'h63; tick();
    cfg_we = 1'b0; tick();
    cfg_addr = 8'h63; tick();

    phase = "R2";
    wr(8'h5F, 8'd1); wr(8'h64, 8'd2); wr(8'hE0, 8'd3); wr(8'h00, 8'd4);
    for (int a = 8'h5F; a <= 8'h64; a++) rd(8'(a));
    rd(8'hE1); rd(8'h20);
    wr(8'h62, 8'hA5); rd(8'h62);

    phase = "R6";
    wr(8'h60, 8'd3); wr(8'h61, 8'd12); wr(8'h62, 8'd14); wr(8'h63, 8'd1);
    pulse_each_pin();

    phase = "R10";
    for (int n = 0; n < 64; n++) begin
      dev_int = dev_int * 32'd1103515245 + 32'd12345 + 32'(n);
      tick();
    end
    dev_int = '0; tick();

    phase = "R1";
    rst_n = 1'b0; repeat (3) tick();
    rst_n = 1'b1; repeat (4) tick();
    for (int a = 8'h60; a <= 8'h63; a++) rd(8'(a));
    dev_int = '1; tick();
    dev_int = '0; tick();

    finish_run();
  end

endmodule